// File: doc/BRIEF.md
# Serial Bitonic Sorter

This block sorts a sequence of unsigned words in place. The words sit in on-chip memory, and a single compare-and-swap unit does every comparison. A host first writes the words through a load port. It then pulses `start` together with the base-2 logarithm of the sequence length. The block then works through every step of a bitonic sorting network, one element pair per clock. A small address generator derives each pair from a running index: it inserts a zero bit at the position of the current merge distance. The same generator takes the compare direction from a higher bit of that index. No table is stored.

The storage is two banks, each with one read port and one write port. An element goes to the bank given by the XOR of all its address bits. The row within that bank is the address with bit 0 dropped. The two members of any pair differ in exactly one address bit, so they always fall in different banks. Each bank therefore serves one read and one write per clock, where a single memory would need four ports.

One idle cycle separates consecutive network steps. This keeps a read from overtaking the write-back of the step before it. When the last write-back has landed, the block raises `done`, and the host reads the result through the read-back port.

Top module: `serial_bitonic_sorter`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: While idle, `load_en` writes `load_data` to element `load_addr`. Setting `rd_addr` in one cycle presents that element on `rd_data` in the next cycle (one register of read latency). Both banks are reachable, and addresses of either parity read back correctly.
- R3: A start accepted with `size_exp` = k (1 to 10) leaves elements 0 to 2^k−1 in non-decreasing unsigned order. Elements at addresses 2^k and above keep their values.
- R4: The sorted region holds exactly the values it held before the start, including every repeated value.
- R5: With k ≥ 1, `done` is first high N = k(k+1)/2 · (2^(k−1)+1) + 1 cycles after the cycle in which `start` is sampled. `busy` is high in every cycle between them.
- R6: An accepted start with k ≥ 1 clears `done` in the next cycle. `done` rises one cycle after the final write-back, together with the fall of `busy`, and then stays high until the next start. `done` and `busy` are never high together.
- R7: While `busy` is high, `start` and `load_en` have no effect. The running sort keeps its length and timing, and no element changes through the load port.
- R8: A start with `size_exp` = 0 (length 1) performs no memory operation. `busy` stays low, `done` is high in the next cycle, and all elements keep their values.
- R9: A `size_exp` above 10 is treated as 10, so all 1024 elements are sorted, with the timing of k = 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write one element while idle |
| load_addr | input | 10 | Element address for a load |
| load_data | input | 16 | Element value for a load |
| start | input | 1 | Begin a sort (sampled while idle) |
| size_exp | input | 4 | Base-2 logarithm of the sequence length |
| busy | output | 1 | Sort in progress |
| done | output | 1 | Last sort finished |
| rd_addr | input | 10 | Element address for read-back |
| rd_data | output | 16 | Element value, one cycle after `rd_addr` |

## Verification
The bench sorts random, reverse-ordered, all-equal and heavily duplicated sequences at several lengths, up to the full memory. A wrong direction bit or a skipped sub-step would leave out-of-order elements at block boundaries. A lost swap operand would show as a missing or doubled value in the sorted region. Sentinel words placed just past the sorted region expose a pair generator that strays beyond the length. The exact cycle count to `done` catches a missing gap cycle or an extra step. A start or load issued mid-sort, a length of one, and an oversized exponent each target control paths that a careless state machine would let restart, touch memory, or index out of range.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int WIDE_W = 16;
    typedef logic [WIDE_W-1:0] wide_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } sbs_state_e;

    typedef struct packed {
        logic asc;        // compare direction: 1 = ascending
        logic last_step;  // final pair of the current network step
        logic last_all;   // final pair of the whole sort
    } pair_flags_t;

    // Open a zero bit at position pos, shifting the bits above it up by one.
    function automatic wide_t spread_zero(wide_t idx, logic [4:0] pos);
        wide_t low_m;
        low_m = (wide_t'(1) << pos) - wide_t'(1);
        return ((idx & ~low_m) << 1) | (idx & low_m);
    endfunction

endpackage

// File: rtl/sbs_bank.sv
module sbs_bank #(
    parameter int DATA_W = 16,
    parameter int ROW_W  = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ROW_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int ROWS = 1 << ROW_W;

    logic [DATA_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sbs_cas.sv
module sbs_cas #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] in_lo,
    input  logic [DATA_W-1:0] in_hi,
    input  logic              asc,
    output logic [DATA_W-1:0] out_lo,
    output logic [DATA_W-1:0] out_hi
);
    logic swap;

    always_comb begin
        swap   = asc ? (in_lo > in_hi) : (in_lo < in_hi);
        out_lo = swap ? in_hi : in_lo;
        out_hi = swap ? in_lo : in_hi;
    end
endmodule

// File: rtl/sbs_addr_gen.sv
module sbs_addr_gen
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int EXP_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic              adv,
    output logic [ADDR_W-1:0] pair_lo,
    output logic [ADDR_W-1:0] pair_hi,
    output pair_flags_t       flags
);
    logic [EXP_W-1:0]  stage_q, sub_q, exp_q;
    logic [ADDR_W-1:0] idx_q, half_m1;
    logic [ADDR_W:0]   lo_ext, lo_shift;
    wide_t             spread;

    always_comb begin
        half_m1         = (ADDR_W'(1) << (exp_q - EXP_W'(1))) - ADDR_W'(1);
        spread          = spread_zero(wide_t'(idx_q), 5'(sub_q));
        pair_lo         = spread[ADDR_W-1:0];
        pair_hi         = pair_lo | (ADDR_W'(1) << sub_q);
        lo_ext          = {1'b0, pair_lo};
        lo_shift        = lo_ext >> (stage_q + EXP_W'(1));
        flags.asc       = ~lo_shift[0];
        flags.last_step = (idx_q == half_m1);
        flags.last_all  = flags.last_step && (sub_q == '0)
                          && (stage_q == exp_q - EXP_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            sub_q   <= '0;
            idx_q   <= '0;
            exp_q   <= EXP_W'(1);
        end else if (init) begin
            stage_q <= '0;
            sub_q   <= '0;
            idx_q   <= '0;
            exp_q   <= exp_in;
        end else if (adv) begin
            if (flags.last_step) begin
                idx_q <= '0;
                if (sub_q == '0) begin
                    stage_q <= stage_q + EXP_W'(1);
                    sub_q   <= stage_q + EXP_W'(1);
                end else begin
                    sub_q <= sub_q - EXP_W'(1);
                end
            end else begin
                idx_q <= idx_q + ADDR_W'(1);
            end
        end
    end

    AST_PAIR_IN_LEN: assert property (@(posedge clk) disable iff (rst)
        adv |-> ({1'b0, pair_hi} < ((ADDR_W+1)'(1) << exp_q)))
        else $error("pair beyond sequence length"); // R3
endmodule

// File: rtl/serial_bitonic_sorter.sv
module serial_bitonic_sorter
    import sbs_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int MAX_LEN = 1024,
    localparam int ADDR_W = $clog2(MAX_LEN),
    localparam int EXP_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    input  logic [EXP_W-1:0]  size_exp,
    output logic              busy,
    output logic              done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ROW_W = ADDR_W - 1;

    sbs_state_e              state;
    logic                    done_q;
    logic [EXP_W-1:0]        exp_eff;
    logic                    accept, issue, host_we;
    logic [ADDR_W-1:0]       pr_lo, pr_hi, wb_lo, wb_hi;
    pair_flags_t             pr_flags, wb_flags;
    logic                    pr_par, wb_par, wb_v, rd_sel_q;
    logic [1:0][DATA_W-1:0]  bank_q;
    logic [DATA_W-1:0]       op_lo, op_hi, y_lo, y_hi;

    always_comb begin
        exp_eff = (size_exp > EXP_W'(ADDR_W)) ? EXP_W'(ADDR_W) : size_exp;
        accept  = start && (state == ST_IDLE);
        issue   = (state == ST_RUN);
        host_we = load_en && (state == ST_IDLE);
        pr_par  = ^pr_lo;
        wb_par  = ^wb_lo;
        op_lo   = bank_q[wb_par];
        op_hi   = bank_q[~wb_par];
        busy    = (state != ST_IDLE);
        done    = done_q;
        rd_data = rd_sel_q ? bank_q[1] : bank_q[0];
    end

    sbs_addr_gen #(.ADDR_W(ADDR_W), .EXP_W(EXP_W)) u_agen (
        .clk     (clk),
        .rst     (rst),
        .init    (accept && (exp_eff != '0)),
        .exp_in  (exp_eff),
        .adv     (issue),
        .pair_lo (pr_lo),
        .pair_hi (pr_hi),
        .flags   (pr_flags)
    );

    sbs_cas #(.DATA_W(DATA_W)) u_cas (
        .in_lo  (op_lo),
        .in_hi  (op_hi),
        .asc    (wb_flags.asc),
        .out_lo (y_lo),
        .out_hi (y_hi)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic SEL = (b == 1);
        logic              we;
        logic [ROW_W-1:0]  wa, ra;
        logic [DATA_W-1:0] wd;

        always_comb begin
            if (wb_v) begin
                we = 1'b1;
                wa = (wb_par == SEL) ? wb_lo[ADDR_W-1:1] : wb_hi[ADDR_W-1:1];
                wd = (wb_par == SEL) ? y_lo : y_hi;
            end else begin
                we = host_we && ((^load_addr) == SEL);
                wa = load_addr[ADDR_W-1:1];
                wd = load_data;
            end
            if (issue) begin
                ra = (pr_par == SEL) ? pr_lo[ADDR_W-1:1] : pr_hi[ADDR_W-1:1];
            end else begin
                ra = rd_addr[ADDR_W-1:1];
            end
        end

        sbs_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .we    (we),
            .waddr (wa),
            .wdata (wd),
            .raddr (ra),
            .rdata (bank_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done_q   <= 1'b0;
            wb_v     <= 1'b0;
            wb_lo    <= '0;
            wb_hi    <= '0;
            wb_flags <= '0;
            rd_sel_q <= 1'b0;
        end else begin
            wb_v     <= issue;
            wb_lo    <= pr_lo;
            wb_hi    <= pr_hi;
            wb_flags <= pr_flags;
            rd_sel_q <= ^rd_addr;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (exp_eff == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q <= 1'b0;
                            state  <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (pr_flags.last_step) state <= ST_GAP;
                end
                ST_GAP: begin
                    if (wb_flags.last_all) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= ST_RUN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CAS_ORDER: assert property (@(posedge clk) disable iff (rst)
        wb_v |-> (wb_flags.asc ? (y_lo <= y_hi) : (y_lo >= y_hi)))
        else $error("pair written out of order"); // R3
    AST_CAS_KEEP: assert property (@(posedge clk) disable iff (rst)
        wb_v |-> ((y_lo == op_lo && y_hi == op_hi) || (y_lo == op_hi && y_hi == op_lo)))
        else $error("pair values altered"); // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(done && busy))
        else $error("done while busy"); // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done)
        else $error("done dropped without start"); // R6
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done)
        else $error("busy fell without done"); // R6
endmodule

// File: tb/serial_bitonic_sorter_tb.sv
module serial_bitonic_sorter_tb;
    localparam int DW = 16;
    localparam int ML = 1024;
    localparam int AW = 10;
    localparam int EW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic          start = 1'b0;
    logic [EW-1:0] size_exp = '0;
    logic          busy, done;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    logic [DW-1:0] model [ML];
    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    serial_bitonic_sorter #(.DATA_W(DW), .MAX_LEN(ML)) u_dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .start(start), .size_exp(size_exp),
        .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_word(input int addr, input logic [DW-1:0] val);
        @(negedge clk);
        load_en   = 1'b1;
        load_addr = AW'(addr);
        load_data = val;
        model[addr] = val;
    endtask

    task automatic end_load();
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic read_word(input int addr, output logic [DW-1:0] val);
        @(negedge clk);
        rd_addr = AW'(addr);
        @(negedge clk);
        val = rd_data;
    endtask

    function automatic int exp_cycles(input int k);
        if (k == 0) return 1;
        return (k * (k + 1) / 2) * ((1 << (k - 1)) + 1) + 1;
    endfunction

    task automatic model_sort(input int n);
        for (int a = 1; a < n; a++) begin
            logic [DW-1:0] key;
            int b;
            key = model[a];
            b = a - 1;
            while (b >= 0 && model[b] > key) begin
                model[b + 1] = model[b];
                b = b - 1;
            end
            model[b + 1] = key;
        end
    endtask

    // Pulse start and count cycles until done; first busy/done sample returned.
    task automatic run_sort(input int e, output int cnt, output logic b1, output logic d1);
        @(negedge clk);
        start    = 1'b1;
        size_exp = EW'(e);
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        b1 = busy;
        d1 = done;
        while (!done && cnt < 60000) begin
            @(negedge clk);
            cnt = cnt + 1;
        end
    endtask

    task automatic verify_region(input string tag, input int n);
        logic [DW-1:0] v;
        for (int a = 0; a < n; a++) begin
            read_word(a, v);
            check(tag, int'(v), int'(model[a]));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done), 0);
    endtask

    task automatic t_load_read();
        logic [DW-1:0] v;
        int addrs [6] = '{0, 1, 2, 511, 512, 1023};
        foreach (addrs[i]) load_word(addrs[i], DW'(16'h3000 + i * 7));
        end_load();
        foreach (addrs[i]) begin
            read_word(addrs[i], v);
            check("R2 load then read", int'(v), int'(model[addrs[i]]));
        end
        load_word(511, 16'hBEEF);
        end_load();
        read_word(511, v);
        check("R2 overwrite", int'(v), 16'hBEEF);
    endtask

    // pattern: 0 random, 1 few distinct values, 2 descending, 3 all equal
    task automatic t_sort(input string name, input int e_req, input int k, input int pattern);
        int n, cnt;
        logic b1, d1;
        logic [DW-1:0] v;
        n = 1 << k;
        for (int a = 0; a < n; a++) begin
            logic [DW-1:0] x;
            case (pattern)
                0: x = DW'($urandom);
                1: x = DW'($urandom_range(0, 3));
                2: x = DW'(n - a);
                default: x = 16'h0777;
            endcase
            load_word(a, x);
        end
        for (int a = n; a < n + 4 && a < ML; a++) load_word(a, DW'(16'hA5A0 + a));
        end_load();
        run_sort(e_req, cnt, b1, d1);
        $display("sort %s: length %0d, %0d cycles", name, n, cnt);
        check("R5 cycles to done", cnt, exp_cycles(k));
        check("R5 busy after start", int'(b1), 1);
        check("R6 done cleared by start", int'(d1), 0);
        check("R6 busy low at done", int'(busy), 0);
        model_sort(n);
        if (pattern == 1) verify_region("R4 duplicates kept", n);
        else verify_region("R3 sorted value", n);
        for (int a = n; a < n + 4 && a < ML; a++) begin
            read_word(a, v);
            check("R3 beyond length untouched", int'(v), int'(model[a]));
        end
        @(negedge clk);
        check("R6 done held", int'(done), 1);
    endtask

    task automatic t_zero_len();
        int cnt;
        logic b1, d1;
        load_word(0, 16'd9);
        load_word(1, 16'd3);
        end_load();
        run_sort(0, cnt, b1, d1);
        check("R8 done next cycle", cnt, 1);
        check("R8 busy stays low", int'(b1), 0);
        check("R8 done high", int'(d1), 1);
        verify_region("R8 data unchanged", 2);
    endtask

    task automatic t_busy_ignore();
        int cnt;
        logic [DW-1:0] v;
        for (int a = 0; a < 8; a++) load_word(a, DW'(100 - a * 3));
        load_word(200, 16'h0BAD);
        end_load();
        @(negedge clk);
        start = 1'b1;
        size_exp = EW'(3);
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        @(negedge clk);
        cnt = 2;
        load_en = 1'b1; load_addr = AW'(2); load_data = 16'hFFFF;
        start = 1'b1; size_exp = EW'(1);
        @(negedge clk);
        cnt = 3;
        load_addr = AW'(200); load_data = 16'h1234;
        @(negedge clk);
        cnt = 4;
        load_en = 1'b0; start = 1'b0;
        while (!done && cnt < 60000) begin
            @(negedge clk);
            cnt = cnt + 1;
        end
        check("R7 length kept during busy", cnt, exp_cycles(3));
        model_sort(8);
        verify_region("R7 load ignored in region", 8);
        read_word(200, v);
        check("R7 load ignored outside region", int'(v), 16'h0BAD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_read();
        t_sort("k1 random", 1, 1, 0);
        t_sort("k2 duplicates", 2, 2, 1);
        t_sort("k3 random", 3, 3, 0);
        t_sort("k4 descending", 4, 4, 2);
        t_sort("k5 duplicates", 5, 5, 1);
        t_sort("k6 all equal", 6, 6, 3);
        t_sort("k7 random", 7, 7, 0);
        t_zero_len();
        t_busy_ignore();
        // R9: exponent 15 clamps to the full 1024-element memory
        t_sort("R9 clamp", 15, 10, 1);
        summary();
        $finish;
    end
endmodule